// File: doc/BRIEF.md
# Slow-Clock Compare Timer

This block is a 16-bit up-counter clocked by a slow kernel clock that is asynchronous to the bus clock. It has a wrap limit (the auto-reload value) and a compare value. Software on the fast bus clock programs the control bits, the compare value, the wrap limit and the interrupt enables through a small register port. It reads back a status word and a copy of the running count. Compare and wrap-limit writes are carried into the kernel domain by a toggle handshake. A write-done flag is raised in the bus domain once the new value is in use.

The compare flag is edge-based: it is raised when the kernel's test "count >= compare" turns from false to true. It is not raised on equality. So lowering the compare value below a running count that had not yet reached the old value raises a match on the next kernel edge. A clear written right after such a compare write cannot cancel that match, because the new value only takes effect two kernel edges later. Each flag is cleared by writing a 1 to its bit in the clear register. The four flags, each gated by its enable, are merged into one registered interrupt line.

Register offsets on `addr`: 0 control (bit0 enable, bit1 run), 1 compare, 2 wrap limit, 3 status (read), 4 clear (write-1), 5 interrupt enable, 6 count (read). Status, clear and enable share one layout: bit0 compare match, bit1 wrap match, bit2 compare write done, bit3 wrap-limit write done.

Top module: `slowclk_cmp_timer`

## Requirements
- R1: After reset the status word reads 0, the count reads 0 and `irq` is low. The compare value is 0 and the wrap limit is 0xFFFF.
- R2: With enable and run both set, the count advances by one on each kernel edge. On the edge where the count equals the wrap limit, the count goes to 0 and status bit1 is set.
- R3: Status bit0 is set on the kernel edge after the one at which "count >= compare" changes from false to true.
- R4: If the compare value is rewritten to a value at or below the running count while "count >= compare" was false, status bit0 is set. A clear of bit0 written right after that compare write does not prevent it.
- R5: If the compare value is rewritten while "count >= compare" is already true and stays true, status bit0 is not set again.
- R6: A compare write sets status bit2 and a wrap-limit write sets status bit3 once the value has reached the kernel domain, two kernel edges after the write. Reading offsets 1 and 2 returns the last written values.
- R7: Writing to the clear register clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A flag set arriving in the same cycle as its clear wins.
- R8: `irq` is high exactly when some status bit is set and its bit in the enable register is also set.
- R9: While enable is 0 the count is held at 0 and no match flags are raised. With enable set and run clear, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain (also synchronised into the kernel domain) |
| kclk | input | 1 | Slow kernel clock, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wdata | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data for `addr` |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with CNT_W=16 and SYNC_STAGES=2, and programs the wrap limit at run time to 40 so that wraps, compare crossings and repeated matches all occur in a few hundred kernel edges. The kernel clock runs at one sixteenth of the bus clock with a phase offset, so its edges never coincide with bus edges and every crossing has a definite latency. That brings the corner cases within reach: a compare lowered under a count that has not yet reached it, a compare rewritten after a match, and a clear issued right behind a compare write.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMP  = 3'd1;
  localparam logic [2:0] A_ARR  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_CLR  = 3'd4;
  localparam logic [2:0] A_IER  = 3'd5;
  localparam logic [2:0] A_CNT  = 3'd6;

  localparam int NFLAG   = 4;
  localparam int F_CMPM  = 0;
  localparam int F_ARRM  = 1;
  localparam int F_CMPOK = 2;
  localparam int F_ARROK = 3;
endpackage

// File: rtl/sct_sync.sv
module sct_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    st[0] <= d;
    for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sct_handoff.sv
module sct_handoff #(
  parameter int          W       = 16,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         kclk,
  input  logic         krst,
  output logic [W-1:0] kdata,
  output logic         ok_pulse
);
  logic [W-1:0] hold;
  logic         req_tog;
  logic         req_k;
  logic         seen;
  logic         ack_b;
  logic         ack_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= RST_VAL;
      req_tog <= 1'b0;
    end else if (wr) begin
      hold    <= wdata;
      req_tog <= ~req_tog;
    end
  end

  sct_sync #(.W(1), .STAGES(STAGES-1)) u_req_sync (
    .clk(kclk), .d(req_tog), .q(req_k)
  );

  always_ff @(posedge kclk) begin
    if (krst) begin
      kdata <= RST_VAL;
      seen  <= 1'b0;
    end else if (req_k != seen) begin
      kdata <= hold;
      seen  <= req_k;
    end
  end

  sct_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk), .d(seen), .q(ack_b)
  );

  always_ff @(posedge clk) begin
    if (rst) ack_prev <= 1'b0;
    else     ack_prev <= ack_b;
  end

  assign ok_pulse = (ack_b != ack_prev);
endmodule

// File: rtl/sct_kernel.sv
module sct_kernel #(
  parameter int W = 16
) (
  input  logic         kclk,
  input  logic         krst,
  input  logic         en,
  input  logic         go,
  input  logic [W-1:0] cmp_k,
  input  logic [W-1:0] arr_k,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_gray,
  output logic         cmp_tog,
  output logic         arr_tog
);
  logic         ge;
  logic         ge_prev;
  logic         wrap;
  logic [W-1:0] nxt;

  always_comb begin
    ge   = (cnt >= cmp_k);
    wrap = (cnt == arr_k);
    if (!en)      nxt = '0;
    else if (!go) nxt = cnt;
    else if (wrap) nxt = '0;
    else          nxt = cnt + 1'b1;
  end

  always_ff @(posedge kclk) begin
    if (krst) begin
      cnt      <= '0;
      cnt_gray <= '0;
      ge_prev  <= 1'b0;
      cmp_tog  <= 1'b0;
      arr_tog  <= 1'b0;
    end else begin
      cnt      <= nxt;
      cnt_gray <= nxt ^ (nxt >> 1);
      if (!en) begin
        ge_prev <= 1'b0;
      end else if (go) begin
        ge_prev <= ge;
        if (ge && !ge_prev) cmp_tog <= ~cmp_tog;
        if (wrap)           arr_tog <= ~arr_tog;
      end
    end
  end
endmodule

// File: rtl/sct_regs.sv
module sct_regs
  import sct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_data,
  output logic             irq,
  output logic [1:0]       ctrl,
  output logic             cmp_wr,
  output logic             arr_wr,
  input  logic             cmp_ok,
  input  logic             arr_ok,
  input  logic [W-1:0]     cnt_gray,
  input  logic             cmp_tog,
  input  logic             arr_tog,
  output logic [NFLAG-1:0] flags,
  output logic             cmp_evt
);
  logic [NFLAG-1:0] ier;
  logic [W-1:0]     cmp_sh;
  logic [W-1:0]     arr_sh;
  logic             cmp_prev;
  logic             arr_prev;
  logic             arr_evt;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [W-1:0]     cnt_bin;

  assign cmp_wr  = wr_en && (addr == A_CMP);
  assign arr_wr  = wr_en && (addr == A_ARR);
  assign cmp_evt = (cmp_tog != cmp_prev);
  assign arr_evt = (arr_tog != arr_prev);

  always_comb begin
    set_v          = '0;
    set_v[F_CMPM]  = cmp_evt;
    set_v[F_ARRM]  = arr_evt;
    set_v[F_CMPOK] = cmp_ok;
    set_v[F_ARROK] = arr_ok;
    clr_v = (wr_en && (addr == A_CLR)) ? wdata[NFLAG-1:0] : '0;
  end

  always_comb begin
    cnt_bin[W-1] = cnt_gray[W-1];
    for (int i = W - 2; i >= 0; i--) cnt_bin[i] = cnt_bin[i+1] ^ cnt_gray[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      ier      <= '0;
      cmp_sh   <= '0;
      arr_sh   <= '1;
      cmp_prev <= 1'b0;
      arr_prev <= 1'b0;
      flags    <= '0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      cmp_prev <= cmp_tog;
      arr_prev <= arr_tog;
      flags    <= (flags & ~clr_v) | set_v;
      irq      <= |(flags & ier);
      if (wr_en) begin
        case (addr)
          A_CTRL:  ctrl   <= wdata[1:0];
          A_CMP:   cmp_sh <= wdata;
          A_ARR:   arr_sh <= wdata;
          A_IER:   ier    <= wdata[NFLAG-1:0];
          default: ;
        endcase
      end
      case (addr)
        A_CTRL:  rd_data <= W'(ctrl);
        A_CMP:   rd_data <= cmp_sh;
        A_ARR:   rd_data <= arr_sh;
        A_STAT:  rd_data <= W'(flags);
        A_IER:   rd_data <= W'(ier);
        A_CNT:   rd_data <= cnt_bin;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/slowclk_cmp_timer.sv
module slowclk_cmp_timer
  import sct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kclk,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int XW = CNT_W + 2;

  logic             krst;
  logic [1:0]       ctrl;
  logic [1:0]       ctrl_k;
  logic             en_k;
  logic             go_k;
  logic             cmp_wr;
  logic             arr_wr;
  logic             cmp_ok;
  logic             arr_ok;
  logic [CNT_W-1:0] cmp_k;
  logic [CNT_W-1:0] arr_k;
  logic [CNT_W-1:0] cnt_k;
  logic [CNT_W-1:0] gray_k;
  logic             cmp_tog;
  logic             arr_tog;
  logic [XW-1:0]    xk;
  logic [XW-1:0]    xb;
  logic [NFLAG-1:0] flags;
  logic             cmp_evt;

  sct_sync #(.W(1), .STAGES(SYNC_STAGES)) u_krst_sync (
    .clk(kclk), .d(rst), .q(krst)
  );

  sct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(kclk), .d(ctrl), .q(ctrl_k)
  );
  assign en_k = ctrl_k[0];
  assign go_k = ctrl_k[1];

  sct_handoff #(.W(CNT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cmp_xfer (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(wdata),
    .kclk(kclk), .krst(krst), .kdata(cmp_k), .ok_pulse(cmp_ok)
  );

  sct_handoff #(.W(CNT_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_arr_xfer (
    .clk(clk), .rst(rst), .wr(arr_wr), .wdata(wdata),
    .kclk(kclk), .krst(krst), .kdata(arr_k), .ok_pulse(arr_ok)
  );

  sct_kernel #(.W(CNT_W)) u_kernel (
    .kclk(kclk), .krst(krst), .en(en_k), .go(go_k),
    .cmp_k(cmp_k), .arr_k(arr_k), .cnt(cnt_k), .cnt_gray(gray_k),
    .cmp_tog(cmp_tog), .arr_tog(arr_tog)
  );

  assign xk = {arr_tog, cmp_tog, gray_k};

  sct_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk(clk), .d(xk), .q(xb)
  );

  sct_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .irq(irq), .ctrl(ctrl),
    .cmp_wr(cmp_wr), .arr_wr(arr_wr), .cmp_ok(cmp_ok), .arr_ok(arr_ok),
    .cnt_gray(xb[CNT_W-1:0]), .cmp_tog(xb[CNT_W]), .arr_tog(xb[CNT_W+1]),
    .flags(flags), .cmp_evt(cmp_evt)
  );
endmodule

// File: rtl/sct_checker.sv
module sct_checker
  import sct_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             kclk,
  input logic             krst,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [W-1:0]     wdata,
  input logic [NFLAG-1:0] flags,
  input logic             cmp_evt,
  input logic             en_k,
  input logic [W-1:0]     cnt_k,
  input logic [W-1:0]     cmp_k,
  input logic             cmp_tog
);
  // R7: a clear of bit0 with no coincident set empties the flag
  p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR && wdata[F_CMPM] && !cmp_evt) |=> !flags[F_CMPM]);

  // R7: a set in the same cycle as its clear wins
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_evt && wr_en && addr == A_CLR && wdata[F_CMPM]) |=> flags[F_CMPM]);

  // R2: the count only steps by one, holds, or returns to zero
  p_cnt_step_r2: assert property (@(posedge kclk) disable iff (krst)
    1'b1 |=> (cnt_k == '0 || cnt_k == $past(cnt_k) || (cnt_k - $past(cnt_k)) == W'(1)));

  // R9: while disabled the count goes to zero and no match is raised
  p_disabled_idle_r9: assert property (@(posedge kclk) disable iff (krst)
    !en_k |=> (cnt_k == '0 && $stable(cmp_tog)));

  // R3: a compare match is only raised when count >= compare held
  p_match_needs_ge_r3: assert property (@(posedge kclk) disable iff (krst)
    !$stable(cmp_tog) |-> ($past(cnt_k) >= $past(cmp_k)));
endmodule

bind slowclk_cmp_timer sct_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .kclk(kclk), .krst(krst),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .flags(flags), .cmp_evt(cmp_evt), .en_k(en_k),
  .cnt_k(cnt_k), .cmp_k(cmp_k), .cmp_tog(cmp_tog)
);

// File: tb/slowclk_cmp_timer_test.sv
`timescale 1ns/100ps
module slowclk_cmp_timer_test;
  logic        clk = 1'b0;
  logic        kclk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  slowclk_cmp_timer uut (
    .clk(clk), .rst(rst), .kclk(kclk), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;
  initial begin
    #17;
    forever #40 kclk = ~kclk;
  end

  // behavioural reference model
  logic [15:0] m_cnt = 0, m_cmp = 0, m_arr = 16'hFFFF, m_cmp_h = 0, m_arr_h = 16'hFFFF;
  int          m_cmp_cd = 0, m_arr_cd = 0;
  bit          m_gep = 0, m_r1 = 0, m_r2 = 0;
  bit [1:0]    m_ctrl = 0, m_c1 = 0, m_c2 = 0;
  bit [3:0]    m_flag = 0, m_ier = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_ier = 0; m_ctrl = 0;
    end else if (wr_en) begin
      case (addr)
        3'd0: m_ctrl = wdata[1:0];
        3'd1: begin m_cmp_h = wdata; m_cmp_cd = 2; end
        3'd2: begin m_arr_h = wdata; m_arr_cd = 2; end
        3'd4: m_flag = m_flag & ~wdata[3:0];
        3'd5: m_ier = wdata[3:0];
        default: ;
      endcase
    end
  end

  always @(posedge kclk) begin
    bit ge;
    if (m_r2) begin
      m_cnt = 0; m_gep = 0; m_cmp = 0; m_arr = 16'hFFFF;
    end else begin
      if (!m_c2[0]) begin
        m_cnt = 0; m_gep = 0;
      end else if (m_c2[1]) begin
        ge = (m_cnt >= m_cmp);
        if (ge && !m_gep) m_flag[0] = 1;
        m_gep = ge;
        if (m_cnt == m_arr) begin m_cnt = 0; m_flag[1] = 1; end
        else m_cnt = m_cnt + 16'd1;
      end
      if (m_cmp_cd == 1) begin m_cmp = m_cmp_h; m_flag[2] = 1; end
      if (m_cmp_cd > 0) m_cmp_cd--;
      if (m_arr_cd == 1) begin m_arr = m_arr_h; m_flag[3] = 1; end
      if (m_arr_cd > 0) m_arr_cd--;
    end
    m_r2 = m_r1; m_r1 = rst;
    m_c2 = m_c1; m_c1 = m_ctrl;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); wr_en = 1'b0; addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge kclk);
      repeat (8) @(posedge clk);
    end
  endtask

  logic [15:0] v;

  task automatic check_state(input string req);
    rd(3'd3, v); check({req, " status"}, v, {12'd0, m_flag});
    rd(3'd6, v); check({req, " count"}, v, m_cnt);
    check({req, " irq"}, irq, |(m_flag & m_ier));
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (60) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle(3);
    // R1 reset state
    check_state("R1");
    rd(3'd3, v); check("R1 status zero", v, 16'd0);
    rd(3'd6, v); check("R1 count zero", v, 16'd0);
    rd(3'd1, v); check("R1 compare reset", v, 16'd0);
    rd(3'd2, v); check("R1 wrap reset", v, 16'hFFFF);
    check("R1 irq low", irq, 1'b0);

    // R6 write-done flags and readback
    wr(3'd2, 16'd40);
    settle(3);
    rd(3'd3, v); check("R6 wrap write done", v[3], 1'b1);
    wr(3'd1, 16'd12);
    settle(3);
    rd(3'd3, v); check("R6 compare write done", v[2], 1'b1);
    rd(3'd1, v); check("R6 compare readback", v, 16'd12);
    rd(3'd2, v); check("R6 wrap readback", v, 16'd40);
    check_state("R6");

    // R7 clear by writing ones
    wr(3'd4, 16'h000C);
    settle(1);
    rd(3'd3, v); check("R7 cleared", v, 16'd0);

    // R9 enabled but not running: count holds at zero, no match
    wr(3'd0, 16'd1);
    settle(4);
    check_state("R9");
    rd(3'd6, v); check("R9 held count", v, 16'd0);

    // R2 / R3 run through a compare crossing and a wrap
    wr(3'd0, 16'd3);
    for (int i = 0; i < 50; i++) begin
      settle(1);
      check_state("R2");
    end
    rd(3'd3, v); check("R3 compare match seen", v[0], 1'b1);
    check("R2 wrap match seen", v[1], 1'b1);

    // R4 lowering compare under the running count
    wr(3'd4, 16'h0003);
    for (int i = 0; i < 60 && m_cnt != 16'd5; i++) settle(1);
    wr(3'd1, 16'd2);
    wr(3'd4, 16'h0001);
    settle(4);
    check_state("R4");
    rd(3'd3, v); check("R4 spurious match", v[0], 1'b1);

    // R5 rewrite after match, still above: no new match
    wr(3'd4, 16'h0005);
    for (int i = 0; i < 60 && m_cnt != 16'd20; i++) settle(1);
    wr(3'd1, 16'd15);
    settle(4);
    check_state("R5");
    rd(3'd3, v); check("R5 no new match", v[0], 1'b0);

    // R7 zero bits leave flags alone (bit2 set by the last compare write)
    wr(3'd4, 16'h0000);
    settle(1);
    rd(3'd3, v); check("R7 zero clear no effect", v[2], 1'b1);

    // R8 interrupt gating
    wr(3'd5, 16'h0004);
    settle(1);
    check("R8 irq enabled flag", irq, 1'b1);
    check_state("R8");
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0001);
    settle(1);
    check_state("R8 gate");
    if (m_flag[0] == 1'b0) check("R8 irq masked", irq, 1'b0);

    // R9 disable: count forced to zero, no match flags
    wr(3'd0, 16'd0);
    settle(3);
    wr(3'd4, 16'h000F);
    settle(6);
    check_state("R9 off");
    rd(3'd6, v); check("R9 count zero", v, 16'd0);
    rd(3'd3, v); check("R9 no match", v[1:0], 2'b00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule